// File: doc/BRIEF.md
# Flash Embedded-Operation Suspend Controller

This block models the controller behind the embedded operations of a NOR-style flash array with 64 uniform blocks. Requests arrive already decoded on a command port. The supported requests are program word, erase block, suspend, resume and read word. The controller runs at most one embedded operation at a time. Its length is a fixed number of clock cycles, set by a parameter. The controller can hold one suspended erase and, nested inside it, one suspended program. It reports its state through an 8-bit status vector and an active-low busy output.

The command port is valid/ready. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low in two cases: during the recovery window that follows reset, and while a read response is waiting. The read response port is valid/ready as well. `rd_valid`, `rd_data` and `rd_err` hold steady until a cycle where `rd_ready` is high. The array is kept in a small register model. A program can only clear bits in a word, and an erase sets every word of one block to all ones.

The status vector has these bits:
- Bit 7: ready, meaning no operation is running.
- Bit 6: an erase is suspended.
- Bit 5: erase error.
- Bit 4: program error.
- Bit 2: a program is suspended.
- Bit 1: protected-block error.
- All other bits read 0.

Command codes on `cmd_op` are:
- 0: no operation.
- 1: program.
- 2: erase.
- 3: suspend.
- 4: resume.
- 5: read.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: While `rst_n` is low, any running or suspended operation is dropped without writing the array, status reads 0x80 and `busy_n` reads 1. After release, `cmd_ready` stays low for exactly RECOVERY_CYCLES rising edges and is high after that.
- R2: An accepted program (code 1) ANDs `cmd_data` into the addressed word. `busy_n` is low and status bit 7 is 0 for exactly PROG_CYCLES cycles after the accepting edge.
- R3: An accepted erase (code 2) sets every word of the addressed block to all ones and leaves every other block unchanged. `busy_n` is low for exactly ERASE_CYCLES cycles.
- R4: At the end of a program, a check is made on the word. If the stored word differs from the requested data, meaning a 0 would have had to become 1, status bit 4 is set.
- R5: A suspend (code 3) during a running program sets status bit 2 and raises `busy_n`, and the cycle counter stays frozen. A resume (code 4) continues the counter, so the total busy time is still PROG_CYCLES.
- R6: A suspend during a running erase sets status bit 6. While the erase is suspended, reads of other blocks return array data and a program to another block runs to completion.
- R7: While an erase of block B is suspended, a program to B is rejected with status bit 4 set and the word unchanged. A read of B returns INVALID_WORD with `rd_err`=1.
- R8: A read accepted while an operation runs, or aimed at the block of a suspended program, returns INVALID_WORD with `rd_err`=1. Any other read returns the word with `rd_err`=0. A response is held, and `cmd_ready` stays low, until `rd_ready` is high.
- R9: A suspend with nothing running and a resume with nothing suspended have no effect. A program or erase issued while an operation runs is ignored.
- R10: A suspend of a program started inside an erase suspension gives status bits 6 and 2 together. Resume continues the program first. The erase only resumes with a later resume, after the program has completed.
- R11: A program or erase aimed at a block whose PROT_MASK bit is set is rejected. It sets status bit 1 together with bit 4 (program) or bit 5 (erase).
- R12: Error bits 5, 4 and 1 are cleared when the next program or erase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and power-down, asynchronous assert |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code |
| cmd_blk | input | 6 | Target block |
| cmd_word | input | 2 | Word within block |
| cmd_data | input | 16 | Program data |
| rd_valid | output | 1 | Read response present |
| rd_ready | input | 1 | Read response taken |
| rd_data | output | 16 | Read word or INVALID_WORD |
| rd_err | output | 1 | Read was refused |
| status | output | 8 | Status vector |
| busy_n | output | 1 | Low while an operation runs |

## Verification
A suspend slot that is set wrongly shows up in the status vector at the first sample after the accepting edge. A lost resume shows up as `busy_n` staying high, and a resume applied to the wrong slot shows up as a busy time that does not match. A cycle counter that is not frozen or not continued shows up only when the operation completes, as a busy-cycle total different from PROG_CYCLES or ERASE_CYCLES. A wrong target block or wrong refusal logic shows up one cycle after a read is accepted, in `rd_data` and `rd_err`.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_READ    = 3'd5
  } fsc_op_e;

  localparam int SR_READY = 7;
  localparam int SR_ESUSP = 6;
  localparam int SR_EERR  = 5;
  localparam int SR_PERR  = 4;
  localparam int SR_PSUSP = 2;
  localparam int SR_PROT  = 1;
endpackage

// File: rtl/fsc_op_timer.sv
module fsc_op_timer #(
  parameter int LEN = 12,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = tick && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= '0;
    else if (done)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R5: a suspended (not ticking) operation keeps its count
  a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(cnt));

  // R2: the count never passes the programmed length
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LEN));
endmodule

// File: rtl/fsc_recovery.sv
module fsc_recovery #(
  parameter int REC = 5,
  localparam int CW = $clog2(REC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  logic [CW-1:0] cnt;

  assign ready = (cnt == CW'(REC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!ready) cnt <= cnt + 1'b1;
  end

  // R1: once the recovery window has elapsed it stays open
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/fsc_array.sv
module fsc_array #(
  parameter int NB = 64,
  parameter int NW = 4,
  parameter int DW = 16,
  localparam int BW = $clog2(NB),
  localparam int WW = $clog2(NW),
  localparam int AW = BW + WW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          er_en,
  input  logic [BW-1:0] er_blk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] vf_addr,
  output logic [DW-1:0] vf_data
);
  logic [DW-1:0] mem [NB*NW];

  assign rd_data = mem[rd_addr];
  assign vf_data = mem[vf_addr];

  always_ff @(posedge clk) begin
    if (er_en) begin
      for (int w = 0; w < NW; w++) mem[{er_blk, WW'(w)}] <= '1;
    end
    if (wr_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
  end
endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
  import fsc_pkg::*;
#(
  parameter int NUM_BLOCKS      = 64,
  parameter int BLK_WORDS       = 4,
  parameter int DATA_W          = 16,
  parameter int PROG_CYCLES     = 12,
  parameter int ERASE_CYCLES    = 40,
  parameter int RECOVERY_CYCLES = 5,
  parameter logic [NUM_BLOCKS-1:0] PROT_MASK = {1'b1, {(NUM_BLOCKS-1){1'b0}}},
  parameter logic [DATA_W-1:0] INVALID_WORD = DATA_W'(16'hDEAD),
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int WRD_W = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [WRD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output logic [7:0]        status,
  output logic              busy_n
);
  // operation slots
  logic              p_act, p_susp, e_act, e_susp;
  logic [BLK_W-1:0]  p_blk, e_blk;
  logic [WRD_W-1:0]  p_word;
  logic [DATA_W-1:0] p_data;
  logic              err_prog, err_erase, err_prot;

  logic rec_ready, accept;
  fsc_op_e op;
  logic run_p, run_e, running;
  logic prot_hit, blocked, refuse;
  logic prog_start, prog_rej, erase_start, erase_rej;
  logic susp_go, res_p, res_e, rd_req;
  logic p_done, e_done, verify_fail;
  logic [DATA_W-1:0] arr_rd, arr_vf;

  fsc_recovery #(.REC(RECOVERY_CYCLES)) u_recovery (
    .clk(clk), .rst_n(rst_n), .ready(rec_ready)
  );

  assign cmd_ready = rec_ready & ~rd_valid;
  assign accept    = cmd_valid & cmd_ready;
  assign op        = fsc_op_e'(cmd_op);

  always_comb begin
    run_p    = p_act & ~p_susp;
    run_e    = e_act & ~e_susp & ~p_act;
    running  = run_p | run_e;
    prot_hit = PROT_MASK[cmd_blk];
    blocked  = e_act & (cmd_blk == e_blk);
    refuse   = running | (p_act & (cmd_blk == p_blk)) | blocked;

    prog_start  = accept & (op == OP_PROG) & ~running & ~p_act & ~prot_hit & ~blocked;
    prog_rej    = accept & (op == OP_PROG) & ~running & ~p_act & (prot_hit | blocked);
    erase_start = accept & (op == OP_ERASE) & ~e_act & ~p_act & ~prot_hit;
    erase_rej   = accept & (op == OP_ERASE) & ~e_act & ~p_act & prot_hit;
    susp_go     = accept & (op == OP_SUSPEND) & running;
    res_p       = accept & (op == OP_RESUME) & p_act & p_susp;
    res_e       = accept & (op == OP_RESUME) & e_act & e_susp & ~p_act;
    rd_req      = accept & (op == OP_READ);
  end

  fsc_op_timer #(.LEN(PROG_CYCLES)) u_prog_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .tick(run_p), .done(p_done)
  );

  fsc_op_timer #(.LEN(ERASE_CYCLES)) u_erase_timer (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .tick(run_e), .done(e_done)
  );

  fsc_array #(.NB(NUM_BLOCKS), .NW(BLK_WORDS), .DW(DATA_W)) u_array (
    .clk(clk),
    .wr_en(p_done), .wr_addr({p_blk, p_word}), .wr_data(p_data),
    .er_en(e_done), .er_blk(e_blk),
    .rd_addr({cmd_blk, cmd_word}), .rd_data(arr_rd),
    .vf_addr({p_blk, p_word}), .vf_data(arr_vf)
  );

  assign verify_fail = (arr_vf & p_data) != p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act <= 1'b0; p_susp <= 1'b0; e_act <= 1'b0; e_susp <= 1'b0;
      p_blk <= '0; p_word <= '0; p_data <= '0; e_blk <= '0;
      err_prog <= 1'b0; err_erase <= 1'b0; err_prot <= 1'b0;
    end else begin
      if (prog_start) begin
        p_act <= 1'b1; p_susp <= 1'b0;
        p_blk <= cmd_blk; p_word <= cmd_word; p_data <= cmd_data;
      end else if (p_done) begin
        p_act <= 1'b0; p_susp <= 1'b0;
      end else if (susp_go && run_p) begin
        p_susp <= 1'b1;
      end else if (res_p) begin
        p_susp <= 1'b0;
      end

      if (erase_start) begin
        e_act <= 1'b1; e_susp <= 1'b0; e_blk <= cmd_blk;
      end else if (e_done) begin
        e_act <= 1'b0; e_susp <= 1'b0;
      end else if (susp_go && run_e) begin
        e_susp <= 1'b1;
      end else if (res_e) begin
        e_susp <= 1'b0;
      end

      if (prog_start || prog_rej || erase_start || erase_rej) begin
        err_prog  <= prog_rej;
        err_erase <= erase_rej;
        err_prot  <= prot_hit & (prog_rej | erase_rej);
      end else if (p_done) begin
        err_prog <= verify_fail;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; rd_err <= 1'b0;
    end else if (rd_req) begin
      rd_valid <= 1'b1;
      rd_data  <= refuse ? INVALID_WORD : arr_rd;
      rd_err   <= refuse;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[SR_READY] = ~running;
    status[SR_ESUSP] = e_act & e_susp;
    status[SR_EERR]  = err_erase;
    status[SR_PERR]  = err_prog;
    status[SR_PSUSP] = p_act & p_susp;
    status[SR_PROT]  = err_prot;
  end

  assign busy_n = ~running;

  // R9: an erase never proceeds while a program slot is occupied
  a_r9_one_running: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_act && !e_susp && p_act));

  // R10: the erase stays suspended for as long as the nested program exists
  a_r10_erase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (e_act && e_susp && p_act) |=> (e_act && e_susp));

  // R7: a program never targets the block of the pending erase
  a_r7_blocks_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && e_act) |-> (p_blk != e_blk));

  // R8: a pending read response is held until taken
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_err)));
endmodule

// File: tb/test_flash_suspend_ctrl.sv
module test_flash_suspend_ctrl;
  import fsc_pkg::*;

  localparam int PROG  = 12;
  localparam int ERASE = 40;
  localparam int REC   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_op;
  logic [5:0]  cmd_blk;
  logic [1:0]  cmd_word;
  logic [15:0] cmd_data;
  logic        rd_valid, rd_ready, rd_err;
  logic [15:0] rd_data;
  logic [7:0]  status;
  logic        busy_n;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  flash_suspend_ctrl #(
    .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .RECOVERY_CYCLES(REC)
  ) i_flash_suspend_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_word(cmd_word), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
    .status(status), .busy_n(busy_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // read-response monitor: pops expected items as responses transfer
  always @(negedge clk) begin
    #2;
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual unexpected response %h expected none", rd_data);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {15'd0, rd_err, rd_data}, {15'd0, e});
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (!busy_n) busy_cnt++;
  end

  task automatic issue(logic [2:0] op, int blk, int word, logic [15:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_blk = 6'(blk); cmd_word = 2'(word); cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic read_exp(string req, int blk, int word, logic [15:0] d, logic e);
    exp_q.push_back({e, d});
    tag_q.push_back(req);
    issue(OP_READ, blk, word, 16'h0);
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_blk = '0;
    cmd_word = '0; cmd_data = '0; rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", status, 8'h80);
    check("R1", busy_n, 1);
    check("R1", cmd_ready, 0);
    rst_n = 1'b1;
    repeat (REC - 1) @(negedge clk);
    check("R1", cmd_ready, 0);
    @(negedge clk);
    check("R1", cmd_ready, 1);

    // R3 / R2: erase, program, isolation between blocks
    busy_cnt = 0;
    issue(OP_ERASE, 0, 0, 0);
    check("R3", status, 8'h00);
    wait_idle();
    check("R3", busy_cnt, ERASE);
    issue(OP_ERASE, 1, 0, 0); wait_idle();
    read_exp("R3", 1, 0, 16'hFFFF, 0);
    busy_cnt = 0;
    issue(OP_PROG, 0, 1, 16'h1234);
    check("R2", busy_n, 0);
    wait_idle();
    check("R2", busy_cnt, PROG);
    check("R2", status, 8'h80);
    read_exp("R2", 0, 1, 16'h1234, 0);
    issue(OP_ERASE, 1, 0, 0); wait_idle();
    read_exp("R3", 0, 1, 16'h1234, 0);

    // R4 verify failure, R12 clearing
    issue(OP_PROG, 0, 1, 16'h1235); wait_idle();
    check("R4", status, 8'h90);
    read_exp("R4", 0, 1, 16'h1234, 0);
    issue(OP_PROG, 0, 2, 16'h00FF);
    check("R12", status, 8'h00);
    wait_idle();
    check("R12", status, 8'h80);

    // R5 program suspend / resume
    busy_cnt = 0;
    issue(OP_PROG, 1, 0, 16'hA5A5);
    repeat (3) @(negedge clk);
    issue(OP_SUSPEND, 0, 0, 0);
    check("R5", status, 8'h84);
    check("R5", busy_n, 1);
    read_exp("R8", 0, 1, 16'h1234, 0);
    read_exp("R8", 1, 0, 16'hDEAD, 1);
    repeat (10) @(negedge clk);
    check("R5", busy_n, 1);
    issue(OP_RESUME, 0, 0, 0);
    check("R5", status, 8'h00);
    wait_idle();
    check("R5", busy_cnt, PROG);
    read_exp("R5", 1, 0, 16'hA5A5, 0);

    // R9 ignored commands
    issue(OP_SUSPEND, 0, 0, 0);
    check("R9", status, 8'h80);
    issue(OP_RESUME, 0, 0, 0);
    check("R9", busy_n, 1);
    check("R9", status, 8'h80);
    busy_cnt = 0;
    issue(OP_ERASE, 5, 0, 0);
    issue(OP_PROG, 0, 3, 16'h0000);
    read_exp("R8", 0, 0, 16'hDEAD, 1);
    wait_idle();
    check("R9", busy_cnt, ERASE);
    read_exp("R9", 0, 3, 16'hFFFF, 0);

    // R6 / R7 / R10 erase suspend with nested program
    busy_cnt = 0;
    issue(OP_ERASE, 2, 0, 0);
    repeat (5) @(negedge clk);
    issue(OP_SUSPEND, 0, 0, 0);
    check("R6", status, 8'hC0);
    read_exp("R7", 2, 0, 16'hDEAD, 1);
    issue(OP_PROG, 2, 0, 16'h0000);
    check("R7", status, 8'hD0);
    check("R7", busy_n, 1);
    read_exp("R6", 0, 2, 16'h00FF, 0);
    issue(OP_PROG, 1, 1, 16'h0F0F);
    check("R6", status, 8'h40);
    repeat (3) @(negedge clk);
    issue(OP_SUSPEND, 0, 0, 0);
    check("R10", status, 8'hC4);
    issue(OP_RESUME, 0, 0, 0);
    check("R10", status, 8'h40);
    wait_idle();
    check("R10", status, 8'hC0);
    read_exp("R6", 1, 1, 16'h0F0F, 0);
    issue(OP_RESUME, 0, 0, 0);
    check("R10", busy_n, 0);
    wait_idle();
    check("R10", busy_cnt, ERASE + PROG);
    check("R6", status, 8'h80);
    read_exp("R7", 2, 0, 16'hFFFF, 0);

    // R11 protected block
    issue(OP_ERASE, 63, 0, 0);
    check("R11", status, 8'hA2);
    check("R11", busy_n, 1);
    issue(OP_PROG, 63, 0, 16'h0000);
    check("R11", status, 8'h92);

    // R8 response back-pressure
    rd_ready = 1'b0;
    read_exp("R8", 0, 1, 16'h1234, 0);
    repeat (3) @(negedge clk);
    check("R8", rd_valid, 1);
    check("R8", cmd_ready, 0);
    check("R8", rd_data, 16'h1234);
    rd_ready = 1'b1;
    @(negedge clk);

    // R1 reset aborts a running program
    issue(OP_PROG, 1, 2, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", status, 8'h80);
    check("R1", busy_n, 1);
    rst_n = 1'b1;
    read_exp("R1", 1, 2, 16'hFFFF, 0);
    repeat (4) @(negedge clk);
    check("R8", exp_q.size(), 0);
    summary();
  end
endmodule